// File: doc/BRIEF.md
# Modulo Wrap Timer

This block is a register-programmed 16-bit up-counter meant to serve as a one-shot alarm or a periodic tick. Counting is paced by a selectable source (the system clock, or a slow fixed-rate enable pulse supplied from outside) divided by a power-of-two prescaler. On each prescaled tick the counter advances by one until it equals a programmable wrap value. On the following tick it reloads from a programmable start value. That reload is the wrap event.

A wrap event can set a sticky wrap flag, and the flag can drive an interrupt. A threshold lets the flag be set only on every (T+1)-th wrap. The flag is cleared by a two-step handshake: read the control word while the flag is 1, then write 0 to the flag bit. A wrap that sets the flag again between the read and the write cancels the pending clear, so the next attempt has to read again.

Software reaches four 32-bit words through a word-addressed bus: control/status at address 0, count at 1, start value at 2 and wrap value at 3. A write to the count word loads the start value into the counter, whatever data is written.

Top module: `wrap_timer`

## Requirements
- R1: After reset the count word, the start value and the control word read 0, the wrap value reads 0x0000FFFF, and `irq` is 0.
- R2: On each prescaled tick the counter increments by one. A tick that finds the counter equal to the wrap value M instead reloads the start value I and raises a wrap event. For I ≤ M, after t ticks from a load the count is I + (t mod (M−I+1)).
- R3: The control word holds the prescale select in bits [2:0]. With prescale select P, one tick is produced for every 2^P events of the selected source. The prescaler restarts from zero when a control write moves the source select from a stopped value to a running one.
- R4: The source select sits in control bits [4:3]. Value 1 counts on every system clock and value 2 counts on `slowTick` pulses. Values 0 and 3 stop the counter, and while stopped neither clock edges nor `slowTick` change the count.
- R5: A write of any data to the count word (address 1) loads the counter with the start value and restarts the wrap-event counter. The count word reads with bits [31:16] at zero.
- R6: The threshold T sits in control bits [12:8]. The wrap flag (control bit 7) is set on the wrap event that ends a run of T+1 wraps. The run counter restarts whenever the flag is set, so T = 0 sets the flag on every wrap.
- R7: `irq` is 1 exactly when both the wrap flag and the interrupt enable (control bit 6) are 1.
- R8: A control write with bit 7 at 0 clears the flag only if the control word was read with the flag at 1 since the flag was last set. A write with bit 7 at 1, or a write with bit 7 at 0 without such a read, leaves the flag unchanged.
- R9: If a flag-setting wrap occurs after the arming read and before the clearing write, the flag stays set. A fresh read followed by a write of 0 then clears it.
- R10: Writes to the start value (address 2) and wrap value (address 3) take effect on the next tick and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | Fixed-rate count enable pulse, one clock wide |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Word address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irq | output | 1 | Wrap interrupt |

## Verification
The counting path is swept over three prescale settings, four start/wrap pairs (including start equal to wrap, where every tick is a wrap) and three thresholds. Each case is sampled just before the (T+1)-th wrap and one prescaled tick later. A wrong reload value, an off-by-one period, or a threshold that counts one wrap too many or too few each move one of these samples. Driving `slowTick` by hand separates the two running sources from the stopped ones and shows the prescaler restarting. Hand-placed pulses between the arming read and the clearing write show a clear that lands too early, is lost after a race, or never arms at all.

// File: rtl/wrap_timer_pkg.sv
`timescale 1ns/1ps
package wrap_timer_pkg;

  // Word addresses of the register file
  localparam int REG_CTRL  = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_START = 2;
  localparam int REG_WRAP  = 3;

  // Control word field positions
  localparam int PRE_LSB  = 0;
  localparam int SRC_LSB  = 3;
  localparam int IE_BIT   = 6;
  localparam int FLAG_BIT = 7;
  localparam int TH_LSB   = 8;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_RSVD = 2'd3
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntLoad;
    logic preRestart;
  } dpStrobe_t;

  function automatic logic srcRunning(srcSel_e s);
    return (s == SRC_SYS) || (s == SRC_SLOW);
  endfunction

endpackage

// File: rtl/wrap_timer_ctrl.sv
`timescale 1ns/1ps
module wrap_timer_ctrl
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int TH_W   = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrapPulse,
  input  logic [CNT_W-1:0]  cntVal,
  output dpStrobe_t         dpStb,
  output srcSel_e           srcSel,
  output logic [PS_W-1:0]   preSel,
  output logic [CNT_W-1:0]  initVal,
  output logic [CNT_W-1:0]  modVal,
  output logic              wrapFlag,
  output logic              wrapIe,
  output logic              clrArmed
);

  logic [TH_W-1:0] thresh;
  logic [TH_W-1:0] ovfCnt;
  logic            wrCtrl, wrCount, wrStart, wrWrap, rdCtrl;
  logic            setEvt;
  srcSel_e         newSrc;
  logic            unusedWr;

  assign wrCtrl  = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign wrCount = wrEn && (addr == ADDR_W'(REG_COUNT));
  assign wrStart = wrEn && (addr == ADDR_W'(REG_START));
  assign wrWrap  = wrEn && (addr == ADDR_W'(REG_WRAP));
  assign rdCtrl  = rdEn && (addr == ADDR_W'(REG_CTRL));
  assign newSrc  = srcSel_e'(wrData[SRC_LSB +: 2]);
  assign unusedWr = ^wrData;

  // A wrap that completes the run of thresh+1 wraps sets the flag
  assign setEvt = wrapPulse && (ovfCnt >= thresh);

  assign dpStb.cntLoad    = wrCount;
  assign dpStb.preRestart = wrCtrl && !srcRunning(srcSel) && srcRunning(newSrc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSel  <= '0;
      srcSel  <= SRC_OFF;
      wrapIe  <= 1'b0;
      thresh  <= '0;
      initVal <= '0;
      modVal  <= '1;
    end else begin
      if (wrCtrl) begin
        preSel <= wrData[PRE_LSB +: PS_W];
        srcSel <= newSrc;
        wrapIe <= wrData[IE_BIT];
        thresh <= wrData[TH_LSB +: TH_W];
      end
      if (wrStart) initVal <= wrData[CNT_W-1:0];
      if (wrWrap)  modVal  <= wrData[CNT_W-1:0];
    end
  end

  // Wrap run counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfCnt <= '0;
    end else if (wrCount) begin
      ovfCnt <= '0;
    end else if (wrapPulse) begin
      if (setEvt) ovfCnt <= '0;
      else        ovfCnt <= ovfCnt + 1'b1;
    end
  end

  // Flag with read-then-write-zero clear guard
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrapFlag <= 1'b0;
      clrArmed <= 1'b0;
    end else if (setEvt) begin
      wrapFlag <= 1'b1;
      clrArmed <= 1'b0;
    end else if (wrCtrl && !wrData[FLAG_BIT] && clrArmed) begin
      wrapFlag <= 1'b0;
      clrArmed <= 1'b0;
    end else if (rdCtrl && wrapFlag) begin
      clrArmed <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_CTRL): begin
        rdData[PRE_LSB +: PS_W] = preSel;
        rdData[SRC_LSB +: 2]    = srcSel;
        rdData[IE_BIT]          = wrapIe;
        rdData[FLAG_BIT]        = wrapFlag;
        rdData[TH_LSB +: TH_W]  = thresh;
      end
      ADDR_W'(REG_COUNT): rdData[CNT_W-1:0] = cntVal;
      ADDR_W'(REG_START): rdData[CNT_W-1:0] = initVal;
      default:            rdData[CNT_W-1:0] = modVal;
    endcase
  end

endmodule

// File: rtl/wrap_timer_dp.sv
`timescale 1ns/1ps
module wrap_timer_dp
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  dpStrobe_t        dpStb,
  input  srcSel_e          srcSel,
  input  logic [PS_W-1:0]  preSel,
  input  logic [CNT_W-1:0] initVal,
  input  logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             wrapPulse
);

  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] preMask;
  logic             srcPulse;
  logic             tick;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      preMask[i] = (i < int'(preSel));
    end
  end

  assign srcPulse  = (srcSel == SRC_SYS) || ((srcSel == SRC_SLOW) && slowTick);
  assign tick      = srcPulse && (preCnt >= preMask);
  assign wrapPulse = tick && (cntVal == modVal) && !dpStb.cntLoad;

  always_ff @(posedge clk) begin
    if (!rstN || dpStb.preRestart) begin
      preCnt <= '0;
    end else if (srcPulse) begin
      if (tick) preCnt <= '0;
      else      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (dpStb.cntLoad) begin
      cntVal <= initVal;
    end else if (tick) begin
      if (cntVal == modVal) cntVal <= initVal;
      else                  cntVal <= cntVal + 1'b1;
    end
  end

endmodule

// File: rtl/wrap_timer.sv
`timescale 1ns/1ps
module wrap_timer
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int TH_W   = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  dpStrobe_t        dpStb;
  srcSel_e          srcSel;
  logic [PS_W-1:0]  preSel;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] modVal;
  logic [CNT_W-1:0] cntVal;
  logic             wrapPulse;
  logic             wrapFlag;
  logic             wrapIe;
  logic             clrArmed;

  wrap_timer_ctrl #(
    .CNT_W(CNT_W), .PS_W(PS_W), .TH_W(TH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wrapPulse(wrapPulse), .cntVal(cntVal),
    .dpStb(dpStb), .srcSel(srcSel), .preSel(preSel), .initVal(initVal),
    .modVal(modVal), .wrapFlag(wrapFlag), .wrapIe(wrapIe), .clrArmed(clrArmed)
  );

  wrap_timer_dp #(
    .CNT_W(CNT_W), .PS_W(PS_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .dpStb(dpStb),
    .srcSel(srcSel), .preSel(preSel), .initVal(initVal), .modVal(modVal),
    .cntVal(cntVal), .wrapPulse(wrapPulse)
  );

  assign irq = wrapFlag && wrapIe;

endmodule

// File: rtl/wrap_timer_chk.sv
`timescale 1ns/1ps
module wrap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntLoad,
  input logic             srcOff,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] initVal,
  input logic             wrapPulse,
  input logic             wrapFlag,
  input logic             clrArmed
);

  assert_load_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |=> cntVal == $past(initVal));

  assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> cntVal == $past(initVal));

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (srcOff && !cntLoad) |=> $stable(cntVal));

  assert_flag_from_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrapFlag) |-> $past(wrapPulse));

  assert_clear_needs_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrapFlag && !clrArmed) |=> wrapFlag);

endmodule

bind wrap_timer wrap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk),
  .rstN(rstN),
  .cntLoad(dpStb.cntLoad),
  .srcOff((srcSel == 2'd0) || (srcSel == 2'd3)),
  .cntVal(cntVal),
  .initVal(initVal),
  .wrapPulse(wrapPulse),
  .wrapFlag(wrapFlag),
  .clrArmed(clrArmed)
);

// File: tb/wrap_timer_tb_top.sv
`timescale 1ns/1ps
module wrap_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  wrap_timer dut_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] ctrlWord(int ps, int src, int ie, int th);
    return 32'((th << 8) | (ie << 6) | (src << 3) | ps);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge
  task automatic busWrite(int a, logic [31:0] d);
    wrEn = 1'b1; addr = 2'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(int a, output logic [31:0] d);
    rdEn = 1'b1; addr = 2'(a);
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseSlow();
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic sweepCase(int ps, int i0, int m0, int th, int n);
    int m, p, t, t2;
    logic [31:0] cv, cw;
    logic        irqNow;
    m = 1 << ps;
    p = m0 - i0 + 1;
    busWrite(0, ctrlWord(ps, 0, 1, th));
    busRead(0, cw);
    busWrite(0, ctrlWord(ps, 0, 1, th));
    busWrite(2, 32'(i0));
    busWrite(3, 32'(m0));
    busWrite(1, 32'hDEAD_BEEF);
    busWrite(0, ctrlWord(ps, 1, 1, th));
    repeat (n) @(negedge clk);
    rdEn = 1'b1; addr = 2'd1;
    #1 cv = rdData; irqNow = irq;
    @(negedge clk);
    rdEn = 1'b0;
    busRead(0, cw);
    t  = n / m;
    t2 = (n + 1) / m;
    check($sformatf("R2 R3 R5 count ps=%0d I=%0d M=%0d n=%0d", ps, i0, m0, n),
          cv, 32'(i0 + (t % p)));
    check($sformatf("R6 R7 irq ps=%0d I=%0d M=%0d T=%0d n=%0d", ps, i0, m0, th, n),
          {31'd0, irqNow}, {31'd0, (t / p) >= th + 1});
    check($sformatf("R6 flag ps=%0d I=%0d M=%0d T=%0d n=%0d", ps, i0, m0, th, n),
          {31'd0, cw[7]}, {31'd0, (t2 / p) >= th + 1});
  endtask

  initial begin : watchdog
    #3000000;
    nFails++;
    $display("FAIL watchdog: run hung (R2) actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int starts[4];
    int wraps[4];
    starts = '{0, 2, 5, 7};
    wraps  = '{3, 6, 5, 9};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(0, rv); check("R1 ctrl", rv, 32'h0);
    busRead(1, rv); check("R1 count", rv, 32'h0);
    busRead(2, rv); check("R1 start", rv, 32'h0);
    busRead(3, rv); check("R1 wrap", rv, 32'h0000_FFFF);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R10 readback
    busWrite(2, 32'hFFFF_1234);
    busWrite(3, 32'hABCD_5678);
    busRead(2, rv); check("R10 start readback", rv, 32'h0000_1234);
    busRead(3, rv); check("R10 wrap readback", rv, 32'h0000_5678);

    // Sweep of counting, prescaling and threshold
    for (int ps = 0; ps < 3; ps++) begin
      for (int k = 0; k < 4; k++) begin
        for (int th = 0; th < 3; th++) begin
          int m, p, nA;
          m = 1 << ps;
          p = wraps[k] - starts[k] + 1;
          nA = m * (p * (th + 1) - 1);
          sweepCase(ps, starts[k], wraps[k], th, nA);
          sweepCase(ps, starts[k], wraps[k], th, nA + m);
        end
      end
    end

    // R4 source gating with the slow enable, R3 prescaler restart
    busWrite(0, ctrlWord(1, 0, 0, 0));
    busWrite(2, 32'd0);
    busWrite(3, 32'd9);
    busWrite(1, 32'd0);
    busWrite(0, ctrlWord(1, 2, 0, 0));
    repeat (10) @(negedge clk);
    busRead(1, rv); check("R4 slow source ignores clock", rv, 32'd0);
    repeat (3) pulseSlow();
    busRead(1, rv); check("R3 R4 three slow pulses at div 2", rv, 32'd1);
    busWrite(0, ctrlWord(1, 0, 0, 0));
    repeat (2) pulseSlow();
    repeat (4) @(negedge clk);
    busRead(1, rv); check("R4 stopped select 0 holds", rv, 32'd1);
    busWrite(0, ctrlWord(1, 3, 0, 0));
    repeat (2) pulseSlow();
    repeat (4) @(negedge clk);
    busRead(1, rv); check("R4 stopped select 3 holds", rv, 32'd1);
    busWrite(0, ctrlWord(1, 2, 0, 0));
    pulseSlow();
    busRead(1, rv); check("R3 restart: one pulse no tick", rv, 32'd1);
    pulseSlow();
    busRead(1, rv); check("R3 restart: second pulse ticks", rv, 32'd2);
    busWrite(1, 32'h5555_5555);
    busRead(1, rv); check("R5 count write reloads start", rv, 32'd0);

    // R6 threshold, R8 clear guard; start == wrap so each tick is a wrap
    busWrite(0, ctrlWord(0, 0, 1, 1));
    busRead(0, rv);
    busWrite(0, ctrlWord(0, 0, 1, 1));
    busWrite(2, 32'd5);
    busWrite(3, 32'd5);
    busWrite(1, 32'd0);
    busWrite(0, ctrlWord(0, 2, 1, 1));
    pulseSlow();
    check("R6 first wrap below threshold", {31'd0, irq}, 32'd0);
    pulseSlow();
    check("R6 R7 second wrap sets flag", {31'd0, irq}, 32'd1);
    busWrite(0, ctrlWord(0, 2, 1, 1));
    check("R8 write 0 without read ignored", {31'd0, irq}, 32'd1);
    busWrite(0, ctrlWord(0, 2, 1, 1) | 32'h80);
    check("R8 write 1 ignored", {31'd0, irq}, 32'd1);
    busRead(0, rv); check("R8 flag reads 1", {31'd0, rv[7]}, 32'd1);
    busWrite(0, ctrlWord(0, 2, 1, 1));
    check("R8 read then write 0 clears irq", {31'd0, irq}, 32'd0);
    busRead(0, rv); check("R8 flag reads 0", {31'd0, rv[7]}, 32'd0);
    busWrite(0, ctrlWord(0, 2, 1, 1) | 32'h80);
    busRead(0, rv); check("R8 write 1 does not set", {31'd0, rv[7]}, 32'd0);
    pulseSlow();
    check("R6 run counter restarted", {31'd0, irq}, 32'd0);
    pulseSlow();
    check("R6 flag set again after T+1 wraps", {31'd0, irq}, 32'd1);
    busWrite(0, ctrlWord(0, 2, 0, 0));
    check("R7 irq off with enable 0", {31'd0, irq}, 32'd0);
    busWrite(0, ctrlWord(0, 2, 1, 0));
    check("R7 R8 ctrl write kept flag", {31'd0, irq}, 32'd1);

    // R9 race between arming read and clearing write
    busRead(0, rv);
    pulseSlow();
    busWrite(0, ctrlWord(0, 2, 1, 0));
    check("R9 set between read and write keeps flag", {31'd0, irq}, 32'd1);
    busRead(0, rv);
    busWrite(0, ctrlWord(0, 2, 1, 0));
    check("R9 retried clear succeeds", {31'd0, irq}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule